// File: doc/BRIEF.md
# Privilege-Aware Address Segment Decoder

This block turns a 32-bit virtual address into a physical address, or into an exception code, within the same cycle. It splits the address space into five fixed windows by the top address bits. Two of the windows are direct windows: the block translates them itself by stripping the window base. The other three are mapped windows, and the block sends them to an external translation lookaside buffer (TLB). The TLB answers in the same cycle, and the block folds its answer into the response. Each window is open only to certain privilege modes. An error-level flag changes the lowest window from mapped to identity-mapped.

A request is qualified by `req_valid`. The response side carries `rsp_valid`, which equals `req_valid`. Back-pressure passes straight through: `req_ready` follows `rsp_ready` combinationally. The requester must hold the address and controls stable until it sees `req_valid && req_ready`. The block holds no state, so a stall costs nothing and drops nothing. The TLB lookup strobe `tlb_valid` is raised only for a valid request that targets a mapped window the current mode may use.

Top module: `seg_decoder`

## Requirements
- R1: Addresses 0x00000000–0x7FFFFFFF with `err_level`=1 give `rsp_paddr` equal to the address, read and write both granted, code 0, and no TLB lookup (`tlb_valid`=0). This holds in every mode.
- R2: Addresses 0x00000000–0x7FFFFFFF with `err_level`=0 are mapped in every mode: a valid request raises `tlb_valid`.
- R3: Addresses 0x80000000–0x9FFFFFFF in kernel mode give `rsp_paddr` = address − 0x80000000, read and write granted, and code 0.
- R4: Addresses 0xA0000000–0xBFFFFFFF in kernel mode give `rsp_paddr` = address − 0xA0000000, read and write granted, and code 0.
- R5: Addresses 0xC0000000–0xDFFFFFFF are mapped for supervisor and kernel mode. From user mode they give an address error.
- R6: Addresses 0xE0000000–0xFFFFFFFF are mapped for kernel mode only. From user or supervisor mode they give an address error. The same applies to the two direct windows of R3 and R4.
- R7: `mode` 2'b10 is user and 2'b01 is supervisor. Both 2'b00 and 2'b11 mean kernel.
- R8: An address error gives `rsp_code` 1 for a read or 2 for a write. It also forces `rsp_paddr`=0, no permissions, `rsp_refill`=0 and `tlb_valid`=0.
- R9: For a mapped access, `tlb_status` 0 (hit) gives code 0, `rsp_paddr`=`tlb_paddr`, read granted, and write granted exactly when `tlb_wr_ok`=1.
- R10: `tlb_status` 1 (no match) and 2 (entry invalid) give code 3 for a read and 4 for a write. `rsp_refill`=1 only for status 1.
- R11: `tlb_status` 3 (write to a clean page) gives code 5 with `rsp_refill`=0. Every non-zero code gives `rsp_paddr`=0 and no permissions.
- R12: `rsp_valid`=`req_valid` and `req_ready`=`rsp_ready`. `tlb_vaddr` equals `req_addr` and `tlb_write` equals `req_write`. The TLB result is ignored for any request that does not raise `tlb_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted (follows rsp_ready) |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store access, 0 = load access |
| mode | input | 2 | Privilege mode: 10 user, 01 supervisor, else kernel |
| err_level | input | 1 | Error-level flag; identity-maps the low window |
| tlb_valid | output | 1 | TLB lookup strobe |
| tlb_vaddr | output | 32 | Address presented to the TLB |
| tlb_write | output | 1 | Access direction presented to the TLB |
| tlb_status | input | 2 | TLB answer: 0 hit, 1 no match, 2 invalid, 3 clean page |
| tlb_paddr | input | 32 | Physical address from the TLB on a hit |
| tlb_wr_ok | input | 1 | TLB entry permits writes |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_paddr | output | 32 | Physical address, 0 on any exception |
| rsp_can_read | output | 1 | Read permission granted |
| rsp_can_write | output | 1 | Write permission granted |
| rsp_code | output | 3 | 0 ok, 1/2 address error load/store, 3/4 TLB load/store, 5 TLB modify |
| rsp_refill | output | 1 | Exception came from a TLB no-match |

## Verification
The block has no state, so any wrong decision is visible on the response ports in the same cycle as the request. There is nothing to settle and nothing to wait for. A misdecoded window boundary, a swapped mode encoding, or a lost error-level override each show up as a wrong code, a wrong physical address, or a stray TLB strobe. The bench therefore walks every window edge against every mode, flag, direction and TLB answer, and compares each response at once.

// File: rtl/seg_decoder_pkg.sv
package seg_decoder_pkg;

  typedef enum logic [2:0] {
    WIN_LOW   = 3'd0,
    WIN_DIR0  = 3'd1,
    WIN_DIR1  = 3'd2,
    WIN_SUPV  = 3'd3,
    WIN_TOP   = 3'd4
  } win_e;

  typedef enum logic [2:0] {
    CODE_OK      = 3'd0,
    CODE_AE_LD   = 3'd1,
    CODE_AE_ST   = 3'd2,
    CODE_TLB_LD  = 3'd3,
    CODE_TLB_ST  = 3'd4,
    CODE_TLB_MOD = 3'd5
  } code_e;

  typedef enum logic [1:0] {
    TST_HIT   = 2'd0,
    TST_MISS  = 2'd1,
    TST_INVAL = 2'd2,
    TST_CLEAN = 2'd3
  } tlb_st_e;

  localparam logic [1:0] MODE_USER = 2'b10;
  localparam logic [1:0] MODE_SUPV = 2'b01;

endpackage

// File: rtl/seg_window_classify.sv
module seg_window_classify
  import seg_decoder_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic [VA_W-1:0] addr,
  input  logic [1:0]      mode,
  input  logic            err_level,
  output win_e            win,
  output logic            allowed,
  output logic            mapped
);
  localparam int TOP = VA_W - 1;

  logic is_user, is_supv, is_kern;

  always_comb begin
    is_user = (mode == MODE_USER);
    is_supv = (mode == MODE_SUPV);
    is_kern = !is_user && !is_supv;

    if (!addr[TOP]) begin
      win = WIN_LOW;
    end else begin
      unique case (addr[TOP-1:TOP-2])
        2'b00:   win = WIN_DIR0;
        2'b01:   win = WIN_DIR1;
        2'b10:   win = WIN_SUPV;
        default: win = WIN_TOP;
      endcase
    end

    unique case (win)
      WIN_LOW:  begin allowed = 1'b1;               mapped = !err_level; end
      WIN_DIR0: begin allowed = is_kern;            mapped = 1'b0;       end
      WIN_DIR1: begin allowed = is_kern;            mapped = 1'b0;       end
      WIN_SUPV: begin allowed = is_kern || is_supv; mapped = 1'b1;       end
      default:  begin allowed = is_kern;            mapped = 1'b1;       end
    endcase
  end

  always_comb begin
    if (mode == MODE_USER && addr[TOP])
      assert_user_high_denied_R6: assert (!allowed);
  end
endmodule

// File: rtl/seg_direct_xlate.sv
module seg_direct_xlate
  import seg_decoder_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic [VA_W-1:0] addr,
  input  win_e            win,
  output logic [VA_W-1:0] paddr
);
  localparam int WIN_W = VA_W - 3;

  always_comb begin
    if (win == WIN_DIR0 || win == WIN_DIR1)
      paddr = {3'b000, addr[WIN_W-1:0]};
    else
      paddr = addr;
  end

  always_comb begin
    if (win == WIN_DIR0 || win == WIN_DIR1)
      assert_direct_below_window_R3: assert (paddr < addr);
  end
endmodule

// File: rtl/seg_result_merge.sv
module seg_result_merge
  import seg_decoder_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic            allowed,
  input  logic            mapped,
  input  logic            write,
  input  logic [VA_W-1:0] direct_paddr,
  input  logic [1:0]      tlb_status,
  input  logic [VA_W-1:0] tlb_paddr,
  input  logic            tlb_wr_ok,
  output logic [VA_W-1:0] paddr,
  output logic            can_rd,
  output logic            can_wr,
  output code_e           code,
  output logic            refill
);
  tlb_st_e st;

  always_comb begin
    st     = tlb_st_e'(tlb_status);
    paddr  = '0;
    can_rd = 1'b0;
    can_wr = 1'b0;
    refill = 1'b0;
    code   = CODE_OK;
    if (!allowed) begin
      code = write ? CODE_AE_ST : CODE_AE_LD;
    end else if (!mapped) begin
      paddr  = direct_paddr;
      can_rd = 1'b1;
      can_wr = 1'b1;
    end else begin
      unique case (st)
        TST_HIT: begin
          paddr  = tlb_paddr;
          can_rd = 1'b1;
          can_wr = tlb_wr_ok;
        end
        TST_MISS: begin
          code   = write ? CODE_TLB_ST : CODE_TLB_LD;
          refill = 1'b1;
        end
        TST_INVAL: code = write ? CODE_TLB_ST : CODE_TLB_LD;
        default:   code = CODE_TLB_MOD;
      endcase
    end
  end

  always_comb begin
    if (code != CODE_OK)
      assert_fault_no_access_R11: assert (!can_rd && !can_wr && paddr == '0);
    if (refill)
      assert_refill_only_tlb_R10: assert (code == CODE_TLB_LD || code == CODE_TLB_ST);
  end
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import seg_decoder_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_addr,
  input  logic            req_write,
  input  logic [1:0]      mode,
  input  logic            err_level,
  output logic            tlb_valid,
  output logic [VA_W-1:0] tlb_vaddr,
  output logic            tlb_write,
  input  logic [1:0]      tlb_status,
  input  logic [VA_W-1:0] tlb_paddr,
  input  logic            tlb_wr_ok,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_can_read,
  output logic            rsp_can_write,
  output logic [2:0]      rsp_code,
  output logic            rsp_refill
);
  win_e            win;
  logic            allowed, mapped;
  logic [VA_W-1:0] direct_paddr;
  code_e           code;

  seg_window_classify #(.VA_W(VA_W)) u_classify (
    .addr(req_addr), .mode(mode), .err_level(err_level),
    .win(win), .allowed(allowed), .mapped(mapped)
  );

  seg_direct_xlate #(.VA_W(VA_W)) u_direct (
    .addr(req_addr), .win(win), .paddr(direct_paddr)
  );

  seg_result_merge #(.VA_W(VA_W)) u_merge (
    .allowed(allowed), .mapped(mapped), .write(req_write),
    .direct_paddr(direct_paddr), .tlb_status(tlb_status),
    .tlb_paddr(tlb_paddr), .tlb_wr_ok(tlb_wr_ok),
    .paddr(rsp_paddr), .can_rd(rsp_can_read), .can_wr(rsp_can_write),
    .code(code), .refill(rsp_refill)
  );

  assign rsp_code  = code;
  assign rsp_valid = req_valid;
  assign req_ready = rsp_ready;
  assign tlb_vaddr = req_addr;
  assign tlb_write = req_write;
  assign tlb_valid = req_valid && allowed && mapped;

  always_comb begin
    if (tlb_valid)
      assert_lookup_not_addr_err_R8: assert (rsp_code != 3'd1 && rsp_code != 3'd2);
    if (req_valid && err_level && !req_addr[VA_W-1])
      assert_low_identity_R1: assert (rsp_paddr == req_addr && !tlb_valid);
    if (req_valid && !err_level && !req_addr[VA_W-1])
      assert_low_mapped_R2: assert (tlb_valid);
  end
endmodule

// File: tb/seg_decoder_test.sv
module seg_decoder_test;
  logic        clk = 1'b0;
  logic        req_valid, req_ready, req_write, err_level;
  logic [31:0] req_addr;
  logic [1:0]  mode;
  logic        tlb_valid, tlb_write, tlb_wr_ok;
  logic [31:0] tlb_vaddr, tlb_paddr;
  logic [1:0]  tlb_status;
  logic        rsp_valid, rsp_ready, rsp_can_read, rsp_can_write, rsp_refill;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_code;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  seg_decoder uut (
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .mode(mode), .err_level(err_level),
    .tlb_valid(tlb_valid), .tlb_vaddr(tlb_vaddr), .tlb_write(tlb_write),
    .tlb_status(tlb_status), .tlb_paddr(tlb_paddr), .tlb_wr_ok(tlb_wr_ok),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_can_read(rsp_can_read), .rsp_can_write(rsp_can_write),
    .rsp_code(rsp_code), .rsp_refill(rsp_refill)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h mode=%b erl=%b wr=%b st=%0d: got %h want %h",
               req, req_addr, mode, err_level, req_write, tlb_status, act, exp);
    end
  endtask

  function automatic logic [31:0] pick_addr(input int i);
    case (i)
      0: return 32'h0000_0000;   1: return 32'h1234_5678;
      2: return 32'h7FFF_FFFF;   3: return 32'h8000_0000;
      4: return 32'h8ABC_DEF0;   5: return 32'h9FFF_FFFF;
      6: return 32'hA000_0000;   7: return 32'hB135_7924;
      8: return 32'hBFFF_FFFF;   9: return 32'hC000_0000;
      10: return 32'hDFFF_FFFF;  11: return 32'hE000_0000;
      12: return 32'hF0F0_1234;  default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic apply_one();
    bit kern, supv, user, allow, mapd, lookup;
    logic [31:0] e_pa; logic e_rd, e_wr, e_rf; logic [2:0] e_code;
    user = (mode == 2'b10);
    supv = (mode == 2'b01);
    kern = !user && !supv;                               // R7
    e_pa = 32'h0; e_rd = 0; e_wr = 0; e_rf = 0; e_code = 3'd0;
    if (req_addr < 32'h8000_0000) begin allow = 1; mapd = !err_level; end
    else if (req_addr < 32'hC000_0000) begin allow = kern; mapd = 0; end
    else if (req_addr < 32'hE000_0000) begin allow = kern || supv; mapd = 1; end
    else begin allow = kern; mapd = 1; end
    lookup = req_valid && allow && mapd;
    if (!allow) e_code = req_write ? 3'd2 : 3'd1;        // R8
    else if (!mapd) begin
      e_rd = 1; e_wr = 1;
      if (req_addr < 32'h8000_0000) e_pa = req_addr;              // R1
      else if (req_addr < 32'hA000_0000) e_pa = req_addr - 32'h8000_0000; // R3
      else e_pa = req_addr - 32'hA000_0000;                       // R4
    end else begin
      case (tlb_status)
        2'd0: begin e_pa = tlb_paddr; e_rd = 1; e_wr = tlb_wr_ok; end // R9
        2'd1: begin e_code = req_write ? 3'd4 : 3'd3; e_rf = 1; end    // R10
        2'd2: e_code = req_write ? 3'd4 : 3'd3;                        // R10
        default: e_code = 3'd5;                                        // R11
      endcase
    end
    #1;
    chk("R12 rsp_valid", {31'b0, rsp_valid}, {31'b0, req_valid});
    chk("R12 req_ready", {31'b0, req_ready}, {31'b0, rsp_ready});
    chk("R12 tlb_vaddr", tlb_vaddr, req_addr);
    chk("R12 tlb_write", {31'b0, tlb_write}, {31'b0, req_write});
    if (req_addr < 32'h8000_0000)
      chk(err_level ? "R1 tlb_valid" : "R2 tlb_valid", {31'b0, tlb_valid}, {31'b0, lookup});
    else if (req_addr >= 32'hC000_0000 && req_addr < 32'hE000_0000)
      chk("R5 tlb_valid", {31'b0, tlb_valid}, {31'b0, lookup});
    else
      chk("R6 tlb_valid", {31'b0, tlb_valid}, {31'b0, lookup});
    chk("R8 rsp_code", {29'b0, rsp_code}, {29'b0, e_code});
    chk("R3 R4 R9 rsp_paddr", rsp_paddr, e_pa);
    chk("R9 R11 rsp_can_read", {31'b0, rsp_can_read}, {31'b0, e_rd});
    chk("R9 R11 rsp_can_write", {31'b0, rsp_can_write}, {31'b0, e_wr});
    chk("R10 rsp_refill", {31'b0, rsp_refill}, {31'b0, e_rf});
    #1;
  endtask

  initial begin
    req_valid = 0; rsp_ready = 0; req_addr = 0; req_write = 0; mode = 2'b00;
    err_level = 0; tlb_status = 0; tlb_paddr = 0; tlb_wr_ok = 0;
    @(negedge clk);
    #1;
    chk("R12 idle rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R12 idle tlb_valid", {31'b0, tlb_valid}, 32'h0);
    for (int a = 0; a < 14; a++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          for (int w = 0; w < 2; w++)
            for (int s = 0; s < 4; s++)
              for (int k = 0; k < 2; k++) begin
                req_addr   = pick_addr(a);
                mode       = 2'(m);
                err_level  = e[0];
                req_write  = w[0];
                tlb_status = 2'(s);
                tlb_wr_ok  = k[0];
                tlb_paddr  = req_addr ^ 32'h5A5A_3C3C;
                req_valid  = ((a + s + k) % 5) != 0;
                rsp_ready  = ((m + w + a) % 3) != 0;
                apply_one();
              end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule